// File: doc/BRIEF.md
# Supply and Fault Auto-Restart Supervisor

This block sequences the supply of a primary-side switching controller. It watches digitised supply-level flags and decides three things: when the high-voltage charger may top up the supply capacitor, when switching may run, and when the gate must be forced low. At power-up it charges the capacitor from the bulk rail until the turn-on level is seen, then lets switching run. While running, it re-enables the charger during switch off-times whenever the supply has sagged below the restart level, until the turn-on level is reached again.

Protection faults are qualified once per switching cycle on a cycle-end strobe. An over-current trip needs a parameterised number of consecutive tripped cycles (two by default) before it latches. Any clean cycle in between clears the count. A brownout (insufficient sense current during on-time) latches at once. A latched fault stops switching and charging. The latch is released when the supply reaches undervoltage, and recharge is held off until the supply falls below a lower fault-restart level. This produces slow hiccup operation.

Top module: `supply_restart_sup`

## Requirements
- R1: While and after reset, state_o is 0 (OFF_CHARGE), run_en is 0, gate_hold is 1 and cause_o is 0 (none).
- R2: In OFF_CHARGE, chg_en equals bulk_ok AND NOT vcc_at_on, in the same cycle. No charging occurs without bulk_ok.
- R3: In OFF_CHARGE, vcc_at_on high with vcc_below_uvlo low moves the state to 1 (RUN) at the next edge. In RUN, run_en is 1 and gate_hold is 0.
- R4: In RUN or OCP_WARN, once vcc_below_restart has been seen, chg_en follows sw_off (gated by bulk_ok) until vcc_at_on is seen. After that the charger stays off until the supply drops below restart again.
- R5: A cycle-end strobe with ocp_flag in RUN moves the state to 2 (OCP_WARN). A clean strobe returns it to RUN. A second consecutive tripped strobe moves it to 3 (FAULT_LATCHED) with cause_o = 1. ocp_flag without a strobe has no effect, and leaving the run states clears the trip count.
- R6: In FAULT_LATCHED and in 4 (FAULT_WAIT_LOW), chg_en and run_en are 0. FAULT_LATCHED holds until vcc_below_uvlo, then moves to FAULT_WAIT_LOW. That state holds until vcc_below_fault, then moves to OFF_CHARGE.
- R7: A cycle-end strobe with bo_flag in RUN or OCP_WARN moves the state to FAULT_LATCHED with cause_o = 2. It takes priority over a simultaneous over-current trip.
- R8: vcc_below_uvlo forces gate_hold to 1 in the same cycle. In RUN or OCP_WARN, it returns the state to OFF_CHARGE at the next edge.
- R9: ocp_flag and bo_flag strobes are ignored in OFF_CHARGE, FAULT_LATCHED and FAULT_WAIT_LOW.
- R10: cause_o keeps the cause of the most recent latched fault after the block has returned to OFF_CHARGE or RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bulk_ok | input | 1 | Bulk rail above the charger start level |
| vcc_at_on | input | 1 | Supply at or above the turn-on level |
| vcc_below_restart | input | 1 | Supply below the self-supply restart level |
| vcc_below_uvlo | input | 1 | Supply below the undervoltage level |
| vcc_below_fault | input | 1 | Supply below the fault-restart level |
| sw_off | input | 1 | Power switch is in its off-time |
| cyc_end | input | 1 | One-cycle strobe at the end of each switching cycle |
| ocp_flag | input | 1 | Over-current comparator tripped in this cycle |
| bo_flag | input | 1 | On-time sense current below the brownout level |
| chg_en | output | 1 | High-voltage charger enable |
| run_en | output | 1 | Switching allowed |
| gate_hold | output | 1 | Force the gate low |
| state_o | output | 3 | State: 0 OFF_CHARGE, 1 RUN, 2 OCP_WARN, 3 FAULT_LATCHED, 4 FAULT_WAIT_LOW |
| cause_o | output | 2 | Last fault cause: 0 none, 1 over-current, 2 brownout |

## Verification
The bench builds the block with the default parameters: two consecutive over-current trips to latch, and brownout detection present. With two trips, the warning state and the latch point are both reached within a handful of strobes. This makes the clean-cycle return, the count clearing on undervoltage and the latch edge directly observable. With brownout enabled, the bench can drive a strobe that carries both flags, so it exercises the priority of brownout over over-current and the full hiccup release sequence for both causes.

// File: rtl/sup_pkg.sv
package sup_pkg;
   typedef enum logic [2:0] {
      ST_OFF_CHARGE     = 3'd0,
      ST_RUN            = 3'd1,
      ST_OCP_WARN       = 3'd2,
      ST_FAULT_LATCHED  = 3'd3,
      ST_FAULT_WAIT_LOW = 3'd4
   } sup_state_t;

   typedef enum logic [1:0] {
      CAUSE_NONE     = 2'd0,
      CAUSE_OCP      = 2'd1,
      CAUSE_BROWNOUT = 2'd2
   } fault_cause_t;
endpackage

// File: rtl/sup_fault_qual.sv
module sup_fault_qual #(
   parameter int OCP_TRIPS   = 2,
   parameter bit BROWNOUT_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic cyc_end,
   input  logic ocp_in,
   input  logic bo_in,
   output logic ocp_fault,
   output logic ocp_warn,
   output logic bo_fault
);
   localparam int CNT_W = (OCP_TRIPS > 2) ? $clog2(OCP_TRIPS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OCP_TRIPS - 1);

   logic [CNT_W-1:0] trip_cnt;
   logic             ocp_strobe;

   assign ocp_strobe = active && cyc_end && ocp_in;
   assign ocp_fault  = ocp_strobe && (trip_cnt == LAST);
   assign ocp_warn   = ocp_strobe && !ocp_fault;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       trip_cnt <= '0;
      else if (!active) trip_cnt <= '0;
      else if (cyc_end) trip_cnt <= ocp_warn ? trip_cnt + 1'b1 : '0;
   end

   generate
      if (BROWNOUT_EN) begin : g_bo
         assign bo_fault = active && cyc_end && bo_in;
      end else begin : g_no_bo
         logic unused_bo;
         assign unused_bo = bo_in;
         assign bo_fault  = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/sup_state_fsm.sv
module sup_state_fsm
   import sup_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         vcc_at_on,
   input  logic         vcc_below_uvlo,
   input  logic         vcc_below_fault,
   input  logic         cyc_end,
   input  logic         ocp_fault,
   input  logic         ocp_warn,
   input  logic         bo_fault,
   output sup_state_t   state_q,
   output fault_cause_t cause_q
);
   sup_state_t   state_d;
   fault_cause_t cause_d;

   always_comb begin
      state_d = state_q;
      cause_d = cause_q;
      unique case (state_q)
         ST_OFF_CHARGE:
            if (vcc_at_on && !vcc_below_uvlo) state_d = ST_RUN;
         ST_RUN, ST_OCP_WARN: begin
            if (vcc_below_uvlo) begin
               state_d = ST_OFF_CHARGE;
            end else if (bo_fault) begin
               state_d = ST_FAULT_LATCHED;
               cause_d = CAUSE_BROWNOUT;
            end else if (ocp_fault) begin
               state_d = ST_FAULT_LATCHED;
               cause_d = CAUSE_OCP;
            end else if (ocp_warn) begin
               state_d = ST_OCP_WARN;
            end else if (cyc_end) begin
               state_d = ST_RUN;
            end
         end
         ST_FAULT_LATCHED:
            if (vcc_below_uvlo) state_d = ST_FAULT_WAIT_LOW;
         ST_FAULT_WAIT_LOW:
            if (vcc_below_fault) state_d = ST_OFF_CHARGE;
         default: state_d = ST_OFF_CHARGE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_OFF_CHARGE;
         cause_q <= CAUSE_NONE;
      end else begin
         state_q <= state_d;
         cause_q <= cause_d;
      end
   end
endmodule

// File: rtl/sup_charge_ctl.sv
module sup_charge_ctl
   import sup_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  sup_state_t state,
   input  logic       bulk_ok,
   input  logic       vcc_at_on,
   input  logic       vcc_below_restart,
   input  logic       sw_off,
   output logic       chg_en
);
   logic in_run;
   logic recharge_q;

   assign in_run = (state == ST_RUN) || (state == ST_OCP_WARN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     recharge_q <= 1'b0;
      else if (!in_run || vcc_at_on)  recharge_q <= 1'b0;
      else if (vcc_below_restart)     recharge_q <= 1'b1;
   end

   always_comb begin
      unique case (state)
         ST_OFF_CHARGE:       chg_en = bulk_ok && !vcc_at_on;
         ST_RUN, ST_OCP_WARN: chg_en = bulk_ok && sw_off && !vcc_at_on
                                       && (recharge_q || vcc_below_restart);
         default:             chg_en = 1'b0;
      endcase
   end
endmodule

// File: rtl/supply_restart_sup.sv
module supply_restart_sup
   import sup_pkg::*;
#(
   parameter int OCP_TRIPS   = 2,
   parameter bit BROWNOUT_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bulk_ok,
   input  logic       vcc_at_on,
   input  logic       vcc_below_restart,
   input  logic       vcc_below_uvlo,
   input  logic       vcc_below_fault,
   input  logic       sw_off,
   input  logic       cyc_end,
   input  logic       ocp_flag,
   input  logic       bo_flag,
   output logic       chg_en,
   output logic       run_en,
   output logic       gate_hold,
   output logic [2:0] state_o,
   output logic [1:0] cause_o
);
   initial begin
      if (OCP_TRIPS < 2)
         $error("supply_restart_sup: OCP_TRIPS must be at least 2");
   end

   sup_state_t   state;
   fault_cause_t cause;
   logic         active;
   logic         ocp_fault, ocp_warn, bo_fault;

   assign run_en    = (state == ST_RUN) || (state == ST_OCP_WARN);
   assign active    = run_en && !vcc_below_uvlo;
   assign gate_hold = !run_en || vcc_below_uvlo;
   assign state_o   = state;
   assign cause_o   = cause;

   sup_fault_qual #(
      .OCP_TRIPS   (OCP_TRIPS),
      .BROWNOUT_EN (BROWNOUT_EN)
   ) u_qual (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .cyc_end   (cyc_end),
      .ocp_in    (ocp_flag),
      .bo_in     (bo_flag),
      .ocp_fault (ocp_fault),
      .ocp_warn  (ocp_warn),
      .bo_fault  (bo_fault)
   );

   sup_state_fsm u_fsm (
      .clk             (clk),
      .rst_n           (rst_n),
      .vcc_at_on       (vcc_at_on),
      .vcc_below_uvlo  (vcc_below_uvlo),
      .vcc_below_fault (vcc_below_fault),
      .cyc_end         (cyc_end),
      .ocp_fault       (ocp_fault),
      .ocp_warn        (ocp_warn),
      .bo_fault        (bo_fault),
      .state_q         (state),
      .cause_q         (cause)
   );

   sup_charge_ctl u_chg (
      .clk               (clk),
      .rst_n             (rst_n),
      .state             (state),
      .bulk_ok           (bulk_ok),
      .vcc_at_on         (vcc_at_on),
      .vcc_below_restart (vcc_below_restart),
      .sw_off            (sw_off),
      .chg_en            (chg_en)
   );
endmodule

// File: rtl/sup_restart_chk.sv
module sup_restart_chk
   import sup_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       bulk_ok,
   input logic       vcc_below_uvlo,
   input logic       vcc_below_fault,
   input logic       chg_en,
   input logic       run_en,
   input logic       gate_hold,
   input logic [2:0] state_o
);
   AST_NO_CHG_NO_BULK: assert property (@(posedge clk) disable iff (!rst_n)
      !bulk_ok |-> !chg_en); // R2

   AST_FAULT_NO_CHG: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_FAULT_LATCHED || state_o == ST_FAULT_WAIT_LOW)
      |-> (!chg_en && !run_en)); // R6

   AST_UVLO_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      vcc_below_uvlo |-> gate_hold); // R8

   AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_FAULT_LATCHED && !vcc_below_uvlo)
      |=> (state_o == ST_FAULT_LATCHED)); // R6

   AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_FAULT_WAIT_LOW && !vcc_below_fault)
      |=> (state_o == ST_FAULT_WAIT_LOW)); // R6

   AST_OFF_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_OFF_CHARGE) |=> (state_o != ST_FAULT_LATCHED)); // R9
endmodule

bind supply_restart_sup sup_restart_chk u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .bulk_ok         (bulk_ok),
   .vcc_below_uvlo  (vcc_below_uvlo),
   .vcc_below_fault (vcc_below_fault),
   .chg_en          (chg_en),
   .run_en          (run_en),
   .gate_hold       (gate_hold),
   .state_o         (state_o)
);

// File: tb/supply_restart_sup_bench.sv
`timescale 1ns/1ps
module supply_restart_sup_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bulk_ok = 1'b1;
   logic       vcc_at_on = 1'b0;
   logic       vcc_below_restart = 1'b1;
   logic       vcc_below_uvlo = 1'b1;
   logic       vcc_below_fault = 1'b1;
   logic       sw_off = 1'b0;
   logic       cyc_end = 1'b0;
   logic       ocp_flag = 1'b0;
   logic       bo_flag = 1'b0;
   logic       chg_en, run_en, gate_hold;
   logic [2:0] state_o;
   logic [1:0] cause_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   supply_restart_sup u_supply_restart_sup (
      .clk(clk), .rst_n(rst_n), .bulk_ok(bulk_ok), .vcc_at_on(vcc_at_on),
      .vcc_below_restart(vcc_below_restart), .vcc_below_uvlo(vcc_below_uvlo),
      .vcc_below_fault(vcc_below_fault), .sw_off(sw_off), .cyc_end(cyc_end),
      .ocp_flag(ocp_flag), .bo_flag(bo_flag), .chg_en(chg_en), .run_en(run_en),
      .gate_hold(gate_hold), .state_o(state_o), .cause_o(cause_o)
   );

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic settle();
      #1;
   endtask

   task automatic chk_eq(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic strobe(input logic ocp, input logic bo);
      cyc_end = 1'b1; ocp_flag = ocp; bo_flag = bo;
      tick();
      cyc_end = 1'b0; ocp_flag = 1'b0; bo_flag = 1'b0;
   endtask

   task automatic power_up();
      vcc_below_fault = 1'b0; vcc_below_uvlo = 1'b0;
      vcc_below_restart = 1'b0; vcc_at_on = 1'b1;
      tick();
      vcc_at_on = 1'b0;
   endtask

   task automatic drop_to_fault_low();
      vcc_below_restart = 1'b1; vcc_below_uvlo = 1'b1;
      tick();
      vcc_below_fault = 1'b1;
      tick();
   endtask

   task automatic t_reset();
      tick();
      chk_eq("R1 state in reset", state_o, 0);
      chk_eq("R1 run_en in reset", run_en, 0);
      chk_eq("R1 gate_hold in reset", gate_hold, 1);
      rst_n = 1'b1;
      tick();
      chk_eq("R1 state after reset", state_o, 0);
      chk_eq("R1 cause after reset", cause_o, 0);
   endtask

   task automatic t_charge_off();
      bulk_ok = 1'b1; settle();
      chk_eq("R2 charge with bulk", chg_en, 1);
      bulk_ok = 1'b0; settle();
      chk_eq("R2 no charge without bulk", chg_en, 0);
      bulk_ok = 1'b1;
      tick();
      chk_eq("R2 still off-charge", state_o, 0);
   endtask

   task automatic t_start_and_self_supply();
      vcc_below_fault = 1'b0; vcc_below_uvlo = 1'b0;
      vcc_below_restart = 1'b0; vcc_at_on = 1'b1; settle();
      chk_eq("R2 charger off at turn-on", chg_en, 0);
      tick();
      chk_eq("R3 state run", state_o, 1);
      chk_eq("R3 run_en", run_en, 1);
      chk_eq("R3 gate released", gate_hold, 0);
      vcc_at_on = 1'b0; sw_off = 1'b1; settle();
      chk_eq("R4 no charge above restart", chg_en, 0);
      vcc_below_restart = 1'b1; settle();
      chk_eq("R4 charge below restart in off-time", chg_en, 1);
      tick();
      vcc_below_restart = 1'b0; settle();
      chk_eq("R4 keep charging until turn-on", chg_en, 1);
      sw_off = 1'b0; settle();
      chk_eq("R4 no charge during on-time", chg_en, 0);
      sw_off = 1'b1; vcc_at_on = 1'b1; settle();
      chk_eq("R4 stop at turn-on", chg_en, 0);
      tick();
      vcc_at_on = 1'b0; settle();
      chk_eq("R4 stays off after turn-on", chg_en, 0);
      sw_off = 1'b0;
   endtask

   task automatic t_ocp();
      ocp_flag = 1'b1;
      tick();
      ocp_flag = 1'b0;
      chk_eq("R5 trip without strobe ignored", state_o, 1);
      strobe(1'b1, 1'b0);
      chk_eq("R5 first trip warns", state_o, 2);
      strobe(1'b0, 1'b0);
      chk_eq("R5 clean cycle returns run", state_o, 1);
      strobe(1'b1, 1'b0);
      chk_eq("R5 warn again", state_o, 2);
      strobe(1'b1, 1'b0);
      chk_eq("R5 second trip latches", state_o, 3);
      chk_eq("R5 cause over-current", cause_o, 1);
   endtask

   task automatic t_fault_recover();
      bulk_ok = 1'b1; sw_off = 1'b1; vcc_below_restart = 1'b1; settle();
      chk_eq("R6 no charge when latched", chg_en, 0);
      chk_eq("R6 no run when latched", run_en, 0);
      strobe(1'b1, 1'b1);
      chk_eq("R9 latched ignores flags", state_o, 3);
      chk_eq("R9 cause unchanged", cause_o, 1);
      vcc_below_uvlo = 1'b1;
      tick();
      chk_eq("R6 to wait-low at uvlo", state_o, 4);
      chk_eq("R6 no charge in wait-low", chg_en, 0);
      tick();
      chk_eq("R6 wait-low holds", state_o, 4);
      vcc_below_fault = 1'b1;
      tick();
      chk_eq("R6 back to off-charge", state_o, 0);
      chk_eq("R6 charging resumes", chg_en, 1);
      chk_eq("R10 cause kept", cause_o, 1);
      sw_off = 1'b0;
   endtask

   task automatic t_brownout();
      power_up();
      chk_eq("R7 run before brownout", state_o, 1);
      strobe(1'b1, 1'b1);
      chk_eq("R7 brownout latches", state_o, 3);
      chk_eq("R7 brownout wins priority", cause_o, 2);
      drop_to_fault_low();
      chk_eq("R7 hiccup to off-charge", state_o, 0);
      power_up();
      chk_eq("R10 cause kept in run", cause_o, 2);
   endtask

   task automatic t_uvlo();
      strobe(1'b1, 1'b0);
      chk_eq("R5 warn before uvlo", state_o, 2);
      vcc_below_uvlo = 1'b1; settle();
      chk_eq("R8 gate held at uvlo", gate_hold, 1);
      tick();
      chk_eq("R8 uvlo to off-charge", state_o, 0);
      chk_eq("R8 run_en off", run_en, 0);
      power_up();
      strobe(1'b1, 1'b0);
      chk_eq("R5 count cleared by uvlo", state_o, 2);
      strobe(1'b0, 1'b0);
      vcc_below_uvlo = 1'b1;
      tick();
   endtask

   task automatic t_ignore_off();
      chk_eq("R9 in off-charge", state_o, 0);
      strobe(1'b1, 1'b1);
      chk_eq("R9 off-charge ignores flags", state_o, 0);
      chk_eq("R9 cause untouched", cause_o, 2);
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      t_reset();
      t_charge_off();
      t_start_and_self_supply();
      t_ocp();
      t_fault_recover();
      t_brownout();
      t_uvlo();
      t_ignore_off();
      done = 1'b1;
      report();
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         report();
      end
   end
endmodule